// File: doc/BRIEF.md
# Two-Lane Unfolded Long-Feedback Recursive Filter

This block evaluates the first-order recursion y(n) = a·y(n-9) + x(n) at two samples per clock. Each clock cycle carries one block k made of an even-indexed sample x(2k) and an odd-indexed sample x(2k+1). Both outputs y(2k) and y(2k+1) come out in that same cycle, so the clock runs at half the sample rate. The nine-sample feedback is split into two cross-coupled history chains. The even result feeds the odd lane after four blocks, and the odd result feeds the even lane after five blocks. Together the two chains hold the original nine delays.

Samples and the coefficient are signed Q1.15. Each lane multiplies the coefficient by its feedback sample and rounds the product back to 15 fraction bits. It then adds the incoming sample and clamps the sum to the 16-bit signed range. The outputs are combinational from the present inputs and the stored history. A block is committed to the history at the clock edge only when `in_valid` is high. The coefficient is expected to stay constant between resets. The feedback loop length is a parameter. An odd length gives the cross-coupled arrangement. An even length makes each lane feed itself.

Top module: `iir_unfold2`

## Requirements
- R1: With the default loop length of 9, `y_even` for block k uses as feedback the `y_odd` value of the valid block k-5. An impulse entered on `x_odd` in block 0 therefore shows up on `y_even` in block 5.
- R2: With the default loop length, `y_odd` for block k uses as feedback the `y_even` value of the valid block k-4. An impulse on `x_even` in block 0 appears on `y_odd` in block 4, while `y_even` stays at the input.
- R3: After reset all history is zero. The first 5 valid blocks give `y_even` = `x_even`, and the first 4 give `y_odd` = `x_odd`.
- R4: While `in_valid` is low the history does not move. The outputs are computed from the current inputs against the unchanged history, and the next valid block continues the sequence as if the idle cycles had not occurred.
- R5: The Q2.30 product is rounded as floor((p + 2^14) / 2^15), so an exact half rounds toward plus infinity. With a = 0x4000 (0.5), a feedback of +1 LSB contributes +1 and a feedback of -1 LSB contributes 0.
- R6: The sum of the rounded product and the input is clamped to 0x7FFF on positive overflow and to 0x8000 on negative overflow. This includes the case a = 0x8000 times feedback 0x8000.
- R7: With a = 0, both outputs equal their inputs in every block.
- R8: For any inputs and coefficient, the interleaved output sequence y(0), y(1), y(2), ... equals a serial bit-exact evaluation of the recursion, using rules R5 and R6.
- R9: Asserting `rst_n` low at any time clears all history asynchronously. After release, R3 holds again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one block of two samples per cycle |
| rst_n | input | 1 | Asynchronous active-low reset that clears the history |
| in_valid | input | 1 | Commits the present block to the history at the clock edge |
| coef | input | 16 | Feedback coefficient a, signed Q1.15 |
| x_even | input | 16 | Sample x(2k), signed Q1.15 |
| x_odd | input | 16 | Sample x(2k+1), signed Q1.15 |
| y_even | output | 16 | Result y(2k), signed Q1.15 |
| y_odd | output | 16 | Result y(2k+1), signed Q1.15 |

## Verification
The bench builds the block with its defaults: 16-bit samples, 15 fraction bits and a loop length of 9. The odd loop length selects the cross-coupled variant with chains of five and four blocks, so the lane crossing of R1 and R2 is visible at fixed block numbers. Full 16-bit Q1.15 words put the exact extremes 0x7FFF and 0x8000 within reach, including the one product that overflows before the addition. The rounding tie at ±1 LSB is also reachable.

// File: rtl/iir_unfold2_pkg.sv
package iir_unfold2_pkg;

    localparam int unsigned SAMPLE_W = 16;
    localparam int unsigned FRAC_W   = 15;
    localparam int unsigned LOOP_W   = 9;

    // Delay, in blocks, on the feedback edge leaving lane `lane`
    // when a loop of `loop_dly` samples is unfolded by two.
    function automatic int feedback_depth(input int lane, input int loop_dly);
        return (lane + loop_dly) / 2;
    endfunction

    // An odd loop length sends each lane's result to the other lane.
    function automatic bit lanes_cross(input int loop_dly);
        return (loop_dly % 2) == 1;
    endfunction

endpackage

// File: rtl/iir_unfold2_delay_line.sv
module iir_unfold2_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);

    logic signed [W-1:0] stage [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stage[i] <= '0;
            end
        end else if (shift_en) begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/iir_unfold2_lane_mac.sv
module iir_unfold2_lane_mac #(
    parameter int W    = 16,
    parameter int FRAC = 15
) (
    input  logic signed [W-1:0] coef,
    input  logic signed [W-1:0] fb,
    input  logic signed [W-1:0] xin,
    output logic signed [W-1:0] yout
);

    localparam int PW = 2 * W;
    localparam int XW = PW + 2;
    localparam logic signed [XW-1:0] RND  = {{(XW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [XW-1:0] MAXV = {{(XW+1-W){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {{(XW+1-W){1'b1}}, {(W-1){1'b0}}};

    logic signed [PW-1:0] prod;
    logic signed [XW-1:0] prod_x;
    logic signed [XW-1:0] prod_rnd;
    logic signed [XW-1:0] sum;

    always_comb begin
        prod     = coef * fb;
        prod_x   = {{2{prod[PW-1]}}, prod};
        prod_rnd = (prod_x + RND) >>> FRAC;
        sum      = prod_rnd + {{(XW-W){xin[W-1]}}, xin};
        if (sum > MAXV) begin
            yout = MAXV[W-1:0];
        end else if (sum < MINV) begin
            yout = MINV[W-1:0];
        end else begin
            yout = sum[W-1:0];
        end
    end

endmodule

// File: rtl/iir_unfold2.sv
module iir_unfold2
    import iir_unfold2_pkg::*;
#(
    parameter int W        = SAMPLE_W,
    parameter int FRAC     = FRAC_W,
    parameter int LOOP_DLY = LOOP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] coef,
    input  logic signed [W-1:0] x_even,
    input  logic signed [W-1:0] x_odd,
    output logic signed [W-1:0] y_even,
    output logic signed [W-1:0] y_odd
);

    localparam int DEPTH_FROM_EVEN = feedback_depth(0, LOOP_DLY);
    localparam int DEPTH_FROM_ODD  = feedback_depth(1, LOOP_DLY);

    logic signed [W-1:0] tap_from_even;
    logic signed [W-1:0] tap_from_odd;
    logic signed [W-1:0] fb_even;
    logic signed [W-1:0] fb_odd;

    iir_unfold2_delay_line #(.W(W), .DEPTH(DEPTH_FROM_EVEN)) u_hist_even (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (y_even),
        .dout     (tap_from_even)
    );

    iir_unfold2_delay_line #(.W(W), .DEPTH(DEPTH_FROM_ODD)) u_hist_odd (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_valid),
        .din      (y_odd),
        .dout     (tap_from_odd)
    );

    generate
        if (lanes_cross(LOOP_DLY)) begin : g_cross
            assign fb_even = tap_from_odd;
            assign fb_odd  = tap_from_even;
        end else begin : g_self
            assign fb_even = tap_from_even;
            assign fb_odd  = tap_from_odd;
        end
    endgenerate

    iir_unfold2_lane_mac #(.W(W), .FRAC(FRAC)) u_mac_even (
        .coef (coef),
        .fb   (fb_even),
        .xin  (x_even),
        .yout (y_even)
    );

    iir_unfold2_lane_mac #(.W(W), .FRAC(FRAC)) u_mac_odd (
        .coef (coef),
        .fb   (fb_odd),
        .xin  (x_odd),
        .yout (y_odd)
    );

endmodule

// File: rtl/iir_unfold2_chk.sv
module iir_unfold2_chk #(
    parameter int W        = 16,
    parameter int LOOP_DLY = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic signed [W-1:0] coef,
    input logic signed [W-1:0] x_even,
    input logic signed [W-1:0] x_odd,
    input logic signed [W-1:0] y_even,
    input logic signed [W-1:0] y_odd
);

    localparam int EVEN_WARM = (LOOP_DLY + 1) / 2;
    localparam int ODD_WARM  = LOOP_DLY / 2;
    localparam int CW        = $clog2(LOOP_DLY + 1) + 1;

    logic [CW-1:0] blk_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_cnt <= '0;
        end else if (in_valid && (blk_cnt < CW'(LOOP_DLY))) begin
            blk_cnt <= blk_cnt + 1'b1;
        end
    end

    assert_warm_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_cnt < CW'(EVEN_WARM)) |-> (y_even == x_even));

    assert_warm_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_cnt < CW'(ODD_WARM)) |-> (y_odd == x_odd));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) && $stable(coef) && $stable(x_even) && $stable(x_odd))
            |-> ($stable(y_even) && $stable(y_odd)));

    assert_zero_coef_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (coef == '0) |-> ((y_even == x_even) && (y_odd == x_odd)));

endmodule

bind iir_unfold2 iir_unfold2_chk #(.W(W), .LOOP_DLY(LOOP_DLY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .coef     (coef),
    .x_even   (x_even),
    .x_odd    (x_odd),
    .y_even   (y_even),
    .y_odd    (y_odd)
);

// File: tb/tb_iir_unfold2.sv
module tb_iir_unfold2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] coef = '0;
    logic signed [15:0] x_even = '0;
    logic signed [15:0] x_odd = '0;
    logic signed [15:0] y_even;
    logic signed [15:0] y_odd;

    int checks = 0;
    int errors = 0;
    logic signed [15:0] hist [9];
    logic signed [15:0] last_e;
    logic signed [15:0] last_o;

    always #10 clk = ~clk;

    iir_unfold2 dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .coef     (coef),
        .x_even   (x_even),
        .x_odd    (x_odd),
        .y_even   (y_even),
        .y_odd    (y_odd)
    );

    function automatic logic signed [15:0] mdl(input logic signed [15:0] a,
                                               input logic signed [15:0] fb,
                                               input logic signed [15:0] xi);
        longint p;
        longint s;
        p = longint'(a) * longint'(fb);
        p = (p + 16384) >>> 15;
        s = p + longint'(xi);
        if (s > 32767) return 16'sh7FFF;
        if (s < -32768) return 16'sh8000;
        return s[15:0];
    endfunction

    task automatic check(input string req, input logic signed [15:0] act,
                         input logic signed [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic signed [15:0] a);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        coef = a;
        for (int i = 0; i < 9; i++) hist[i] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One block: drive at the falling edge, compare before the rising edge.
    task automatic drive(input string req, input logic signed [15:0] xe,
                         input logic signed [15:0] xo, input logic v);
        logic signed [15:0] ee;
        logic signed [15:0] eo;
        @(negedge clk);
        x_even = xe;
        x_odd = xo;
        in_valid = v;
        #2;
        ee = mdl(coef, hist[0], xe);
        eo = mdl(coef, hist[1], xo);
        last_e = y_even;
        last_o = y_odd;
        check(req, y_even, ee);
        check(req, y_odd, eo);
        if (v) begin
            for (int i = 0; i < 7; i++) hist[i] = hist[i+2];
            hist[7] = ee;
            hist[8] = eo;
        end
    endtask

    task automatic t_reset_state;
        do_reset(16'sh4000);
        x_even = 16'sh1234;
        x_odd = -16'sh0567;
        #2;
        check("R3 reset even", y_even, 16'sh1234);
        check("R3 reset odd", y_odd, -16'sh0567);
        for (int k = 0; k < 5; k++) begin
            drive("R3 warm", 16'(k * 1000 + 7), 16'(-k * 900 - 3), 1'b1);
            check("R3 warm even", last_e, 16'(k * 1000 + 7));
            if (k < 4) check("R3 warm odd", last_o, 16'(-k * 900 - 3));
        end
    endtask

    task automatic t_impulse_even_to_odd;
        do_reset(16'sh7FFF);
        drive("R2", 16'sh4000, 16'sh0000, 1'b1);
        for (int k = 1; k < 10; k++) begin
            drive("R2", 16'sh0000, 16'sh0000, 1'b1);
            if (k == 4) begin
                check("R2 odd impulse", last_o, 16'sh4000);
                check("R2 even quiet", last_e, 16'sh0000);
            end
            if (k == 9) check("R1 return to even", last_e, 16'sh4000);
        end
    endtask

    task automatic t_impulse_odd_to_even;
        do_reset(16'sh7FFF);
        drive("R1", 16'sh0000, 16'sh2000, 1'b1);
        for (int k = 1; k < 6; k++) begin
            drive("R1", 16'sh0000, 16'sh0000, 1'b1);
            if (k == 4) check("R1 even quiet", last_e, 16'sh0000);
            if (k == 5) check("R1 even impulse", last_e, 16'sh2000);
        end
    endtask

    task automatic t_rounding;
        do_reset(16'sh4000);
        drive("R5", 16'sh0001, -16'sh0001, 1'b1);
        for (int k = 1; k < 6; k++) begin
            drive("R5", 16'sh0000, 16'sh0000, 1'b1);
            if (k == 4) check("R5 half up", last_o, 16'sh0001);
            if (k == 5) check("R5 minus half", last_e, 16'sh0000);
        end
    endtask

    task automatic t_saturation;
        do_reset(16'sh7FFF);
        for (int k = 0; k < 5; k++) drive("R6 pos", 16'sh7FFF, 16'sh7FFF, 1'b1);
        check("R6 pos clamp", last_o, 16'sh7FFF);
        do_reset(16'sh7FFF);
        for (int k = 0; k < 5; k++) drive("R6 neg", 16'sh8000, 16'sh8000, 1'b1);
        check("R6 neg clamp", last_o, 16'sh8000);
        do_reset(16'sh8000);
        drive("R6 prod", 16'sh8000, 16'sh0000, 1'b1);
        for (int k = 1; k < 5; k++) drive("R6 prod", 16'sh0000, 16'sh0000, 1'b1);
        check("R6 min times min", last_o, 16'sh7FFF);
    endtask

    task automatic t_zero_coef;
        do_reset(16'sh0000);
        for (int k = 0; k < 20; k++) begin
            logic signed [15:0] xe;
            logic signed [15:0] xo;
            xe = 16'($urandom);
            xo = 16'($urandom);
            drive("R7", xe, xo, 1'b1);
            check("R7 even pass", last_e, xe);
            check("R7 odd pass", last_o, xo);
        end
    endtask

    task automatic t_random(input logic signed [15:0] a);
        do_reset(a);
        for (int k = 0; k < 60; k++) begin
            drive("R8 serial model", 16'($urandom), 16'($urandom), 1'b1);
        end
    endtask

    task automatic t_stall;
        do_reset(16'sh6000);
        for (int k = 0; k < 12; k++) drive("R4 pre", 16'($urandom), 16'($urandom), 1'b1);
        for (int k = 0; k < 6; k++) drive("R4 idle", 16'($urandom), 16'($urandom), 1'b0);
        for (int k = 0; k < 12; k++) drive("R4 resume", 16'($urandom), 16'($urandom), 1'b1);
    endtask

    task automatic t_async_reset;
        do_reset(16'sh5A5A);
        for (int k = 0; k < 10; k++) drive("R9 pre", 16'sh3000, -16'sh2000, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        #3 rst_n = 1'b0;
        #2 rst_n = 1'b1;
        for (int i = 0; i < 9; i++) hist[i] = '0;
        for (int k = 0; k < 5; k++) begin
            drive("R9 cleared", 16'sh0123, 16'sh0321, 1'b1);
            check("R9 even cleared", last_e, 16'sh0123);
            if (k < 4) check("R9 odd cleared", last_o, 16'sh0321);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_impulse_even_to_odd();
        t_impulse_odd_to_even();
        t_rounding();
        t_saturation();
        t_zero_coef();
        t_random(16'sh7FFF);
        t_random(16'sh8000);
        t_random(16'shC000);
        t_random(16'sh1234);
        t_stall();
        t_async_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule